// File: doc/BRIEF.md
# Oversampled Serial Receiver with Error-Tagged Queue

This block receives asynchronous serial characters on a single line, using a baud tick that runs at sixteen times the bit rate. Each completed character goes into a four-entry first-in first-out queue. Every entry carries the character together with its own parity-mismatch and stop-bit-fault flags. The outputs always show the oldest unread entry and the flags that belong to it. A one-cycle read strobe removes that entry from the queue.

Frames can carry eight data bits with optional even or odd parity, or nine data bits with no parity. In nine-bit mode, an address filter can be switched on. While it is on, only words whose top bit is set enter the queue. A sticky overrun flag reports characters that were lost because the queue was full. A two-bit selector sets the condition that drives the interrupt output.

Top module: `serial_rx_queue`

## Requirements
- R1: A frame is a low start bit, then data bits least significant bit first, then an optional parity bit, then a high stop bit. A completed character appears on `head_data` with `data_avail` high, and `data_avail` is low exactly when no unread entry remains.
- R2: The queue holds up to 4 entries and returns them in arrival order. A one-cycle `pop` removes the head entry. A `pop` while the queue is empty changes nothing.
- R3: With `parity_en` high and `nine_bit` low, one parity bit follows the eighth data bit. `head_perr` is 1 when the parity bit does not match the data. Even parity (`parity_odd`=0) expects an even count of ones across the data and parity bit; odd parity (`parity_odd`=1) expects an odd count.
- R4: If the stop bit is sampled low, the character is still stored, with its `head_ferr` set. The flags of other entries are unaffected.
- R5: If a character completes while 4 entries are held, `overrun` goes high and the character is discarded, leaving the stored entries intact. `overrun` stays high until `clr_overrun` is pulsed.
- R6: A start bit counts only if the line is still low at the eighth baud tick after the low was first seen. A shorter low pulse produces no character.
- R7: `irq_mode` selects the interrupt condition. Values 00 and 01 give a one-cycle pulse for each stored character. Value 10 holds `irq` high while the queue is not empty. Value 11 holds `irq` high while the queue is full.
- R8: With `nine_bit` high, nine data bits are received with no parity bit, and bit 8 of `head_data` carries the ninth bit. With `nine_bit` low, bit 8 of `head_data` reads 0.
- R9: With both `nine_bit` and `addr_detect` high, words whose ninth bit is 0 are dropped without entering the queue. Words whose ninth bit is 1 are stored.
- R10: The baud tick fires once every `baud_div`+1 clock cycles, so one bit lasts 16*(`baud_div`+1) clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_in | input | 1 | Serial line, idle high |
| baud_div | input | 16 | Clock cycles per baud tick, minus one |
| nine_bit | input | 1 | Selects nine data bits per frame |
| parity_en | input | 1 | Adds a parity bit to eight-bit frames |
| parity_odd | input | 1 | 1 selects odd parity, 0 selects even |
| addr_detect | input | 1 | Accept only ninth-bit-set words (nine-bit mode) |
| irq_mode | input | 2 | Interrupt condition selector |
| pop | input | 1 | Removes the head entry |
| clr_overrun | input | 1 | Clears the overrun flag |
| head_data | output | 9 | Data of the oldest unread entry |
| head_perr | output | 1 | Parity error flag of the head entry |
| head_ferr | output | 1 | Framing error flag of the head entry |
| data_avail | output | 1 | Queue holds at least one entry |
| overrun | output | 1 | Sticky lost-character flag |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with the default 16x oversampling, a queue depth of 4 and a 16-bit divisor. It runs most traffic at `baud_div`=1, so one bit lasts 32 clocks. This keeps full-queue, overrun and interrupt-threshold sequences short enough to run several of each. One frame is also sent at `baud_div`=3 to confirm that the bit time scales with the divisor. Because the depth is only 4, the fifth character reaches the overrun path after only a few frames.

// File: rtl/srx_pkg.sv
package srx_pkg;

  typedef struct packed {
    logic [8:0] data;
    logic       perr;
    logic       ferr;
  } srx_word_t;

  localparam int unsigned WORD_W = $bits(srx_word_t);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } srx_state_e;

  function automatic logic parity_mismatch(input logic [7:0] d,
                                           input logic       pbit,
                                           input logic       odd);
    return ((^d) ^ pbit) != odd;
  endfunction

  function automatic logic [3:0] last_bit_index(input logic nine);
    return nine ? 4'd8 : 4'd7;
  endfunction

endpackage

// File: rtl/srx_baud.sv
module srx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt >= div) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + 1'b1;
      tick <= 1'b0;
    end
  end

  // R10: with a nonzero divisor, ticks never come back to back
  a_r10_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick);

endmodule

// File: rtl/srx_frame.sv
module srx_frame
  import srx_pkg::*;
#(
  parameter int OSR = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      rx_s,
  input  logic      nine_bit,
  input  logic      parity_en,
  input  logic      parity_odd,
  output logic      word_valid,
  output srx_word_t word
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID_CNT = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] END_CNT = CW'(OSR - 1);

  srx_state_e     state;
  logic [CW-1:0]  os_cnt;
  logic [3:0]     bit_idx;
  logic [8:0]     shreg;
  logic           pbit;
  logic [8:0]     data_now;

  assign data_now = nine_bit ? shreg : {1'b0, shreg[8:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      os_cnt     <= '0;
      bit_idx    <= '0;
      shreg      <= '0;
      pbit       <= 1'b0;
      word_valid <= 1'b0;
      word       <= '0;
    end else begin
      word_valid <= 1'b0;
      if (tick) begin
        case (state)
          ST_IDLE: begin
            os_cnt <= '0;
            if (!rx_s) state <= ST_START;
          end
          ST_START: begin
            if (os_cnt == MID_CNT) begin
              os_cnt  <= '0;
              bit_idx <= '0;
              state   <= rx_s ? ST_IDLE : ST_DATA;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_DATA: begin
            if (os_cnt == END_CNT) begin
              os_cnt  <= '0;
              shreg   <= {rx_s, shreg[8:1]};
              bit_idx <= bit_idx + 1'b1;
              if (bit_idx == last_bit_index(nine_bit))
                state <= (parity_en && !nine_bit) ? ST_PAR : ST_STOP;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_PAR: begin
            if (os_cnt == END_CNT) begin
              os_cnt <= '0;
              pbit   <= rx_s;
              state  <= ST_STOP;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          ST_STOP: begin
            if (os_cnt == END_CNT) begin
              os_cnt     <= '0;
              word_valid <= 1'b1;
              word.data  <= data_now;
              word.perr  <= parity_en && !nine_bit &&
                            parity_mismatch(data_now[7:0], pbit, parity_odd);
              word.ferr  <= !rx_s;
              state      <= ST_IDLE;
            end else begin
              os_cnt <= os_cnt + 1'b1;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

  // R6: entering the data phase requires a low line at the mid-start sample
  a_r6_start_confirm: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA && $past(state) == ST_START) |-> !$past(rx_s));

  // R1: each frame completes with a single-cycle strobe
  a_r1_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid);

endmodule

// File: rtl/srx_queue.sv
module srx_queue #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [W-1:0]                 wdata,
  input  logic                         pop,
  output logic [W-1:0]                 rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] next_ptr(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_W'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        mem[i] <= '0;
      else if (do_push && wr_ptr == PW'(i))
        mem[i] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (do_pop)  rd_ptr <= next_ptr(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R2: occupancy never exceeds the depth
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));

  // R2: a pop on an empty queue leaves it empty
  a_r2_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && !push) |=> empty);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import srx_pkg::*;
#(
  parameter int DIV_W = 16,
  parameter int OSR   = 16,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             nine_bit,
  input  logic             parity_en,
  input  logic             parity_odd,
  input  logic             addr_detect,
  input  logic [1:0]       irq_mode,
  input  logic             pop,
  input  logic             clr_overrun,
  output logic [8:0]       head_data,
  output logic             head_perr,
  output logic             head_ferr,
  output logic             data_avail,
  output logic             overrun,
  output logic             irq
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic            rx_m, rx_s;
  logic            tick;
  logic            word_valid;
  srx_word_t       word;
  srx_word_t       head;
  logic            addr_drop;
  logic            push_req;
  logic            ovr_event;
  logic            stored_pulse;
  logic [CNT_W-1:0] q_count;
  logic            q_full, q_empty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_m <= 1'b1;
      rx_s <= 1'b1;
    end else begin
      rx_m <= rx_in;
      rx_s <= rx_m;
    end
  end

  srx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk  (clk),
    .rst_n(rst_n),
    .div  (baud_div),
    .tick (tick)
  );

  srx_frame #(.OSR(OSR)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .rx_s      (rx_s),
    .nine_bit  (nine_bit),
    .parity_en (parity_en),
    .parity_odd(parity_odd),
    .word_valid(word_valid),
    .word      (word)
  );

  assign addr_drop = nine_bit && addr_detect && !word.data[8];
  assign push_req  = word_valid && !addr_drop;
  assign ovr_event = push_req && q_full;

  srx_queue #(.W(WORD_W), .DEPTH(DEPTH)) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .push (push_req),
    .wdata(word),
    .pop  (pop),
    .rdata(head),
    .count(q_count),
    .full (q_full),
    .empty(q_empty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overrun      <= 1'b0;
      stored_pulse <= 1'b0;
    end else begin
      stored_pulse <= push_req && !q_full;
      if (ovr_event)        overrun <= 1'b1;
      else if (clr_overrun) overrun <= 1'b0;
    end
  end

  always_comb begin
    case (irq_mode)
      2'b11:   irq = q_full;
      2'b10:   irq = !q_empty;
      default: irq = stored_pulse;
    endcase
  end

  assign head_data  = head.data;
  assign head_perr  = head.perr;
  assign head_ferr  = head.ferr;
  assign data_avail = !q_empty;

  // R5: a lost character raises the overrun flag
  a_r5_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_event |=> overrun);

  // R5: the flag holds until software clears it
  a_r5_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !clr_overrun) |=> overrun);

  // R9: a filtered word leaves the occupancy unchanged
  a_r9_addr_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && addr_drop && !pop) |=> q_count == $past(q_count));

  // R7: in full-threshold mode the interrupt implies pending data
  a_r7_full_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mode == 2'b11 && irq) |-> data_avail);

endmodule

// File: tb/tb_serial_rx_queue.sv
`timescale 1ns/1ps
module tb_serial_rx_queue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_in = 1'b1;
  logic [15:0] baud_div = 16'd1;
  logic        nine_bit = 1'b0;
  logic        parity_en = 1'b0;
  logic        parity_odd = 1'b0;
  logic        addr_detect = 1'b0;
  logic [1:0]  irq_mode = 2'b00;
  logic        pop = 1'b0;
  logic        clr_overrun = 1'b0;
  logic [8:0]  head_data;
  logic        head_perr, head_ferr, data_avail, overrun, irq;

  int total = 0;
  int bad = 0;
  int irq_hi = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  serial_rx_queue dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .baud_div(baud_div),
    .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .addr_detect(addr_detect), .irq_mode(irq_mode), .pop(pop),
    .clr_overrun(clr_overrun), .head_data(head_data), .head_perr(head_perr),
    .head_ferr(head_ferr), .data_avail(data_avail), .overrun(overrun), .irq(irq)
  );

  always @(negedge clk) if (irq) irq_hi++;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_clks();
    return 16 * (int'(baud_div) + 1);
  endfunction

  task automatic line(input logic v);
    @(negedge clk) rx_in = v;
    repeat (bit_clks() - 1) @(negedge clk);
  endtask

  // R1/R3/R8: start, data LSB first, optional parity, stop, one idle bit
  task automatic send(input logic [8:0] d, input int nb, input bit use_par,
                      input bit pval, input bit stopv);
    line(1'b0);
    for (int i = 0; i < nb; i++) line(d[i]);
    if (use_par) line(pval);
    line(stopv);
    line(1'b1);
    line(1'b1);
  endtask

  task automatic do_pop();
    @(negedge clk) pop = 1'b1;
    @(negedge clk) pop = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 reset avail", data_avail, 0);
    check("R5 reset overrun", overrun, 0);
    check("R7 reset irq", irq, 0);
  endtask

  task automatic t_basic();
    send(9'h0A5, 8, 0, 0, 1);
    check("R1 avail", data_avail, 1);
    check("R1 data", head_data, 9'h0A5);
    check("R4 ferr clean", head_ferr, 0);
    check("R3 perr clean", head_perr, 0);
    do_pop();
    check("R1 empty after pop", data_avail, 0);
  endtask

  task automatic t_order();
    send(9'h011, 8, 0, 0, 1);
    send(9'h022, 8, 0, 0, 1);
    send(9'h0F3, 8, 0, 0, 1);
    check("R2 first", head_data, 9'h011); do_pop();
    check("R2 second", head_data, 9'h022); do_pop();
    check("R2 third", head_data, 9'h0F3); do_pop();
    check("R2 drained", data_avail, 0);
    do_pop();
    check("R2 pop empty", data_avail, 0);
    send(9'h07E, 8, 0, 0, 1);
    check("R2 after empty pop", head_data, 9'h07E);
    do_pop();
  endtask

  task automatic t_parity();
    parity_en = 1'b1; parity_odd = 1'b0;
    send(9'h003, 8, 1, 0, 1);
    send(9'h003, 8, 1, 1, 1);
    check("R3 even ok", head_perr, 0); do_pop();
    check("R3 even bad", head_perr, 1);
    check("R3 data kept", head_data, 9'h003); do_pop();
    parity_odd = 1'b1;
    send(9'h003, 8, 1, 1, 1);
    send(9'h007, 8, 1, 1, 1);
    check("R3 odd ok", head_perr, 0); do_pop();
    check("R3 odd bad", head_perr, 1); do_pop();
    parity_en = 1'b0; parity_odd = 1'b0;
  endtask

  task automatic t_framing();
    send(9'h05C, 8, 0, 0, 0);
    send(9'h05D, 8, 0, 0, 1);
    check("R4 ferr set", head_ferr, 1);
    check("R4 stored", head_data, 9'h05C); do_pop();
    check("R4 next clean", head_ferr, 0);
    check("R4 next data", head_data, 9'h05D); do_pop();
  endtask

  task automatic t_overrun();
    for (int i = 0; i < 5; i++) send(9'(8'h40 + i), 8, 0, 0, 1);
    check("R5 overrun set", overrun, 1);
    for (int i = 0; i < 4; i++) begin
      check("R5 kept entry", head_data, 9'(8'h40 + i));
      do_pop();
    end
    check("R5 fifth dropped", data_avail, 0);
    check("R5 sticky", overrun, 1);
    @(negedge clk) clr_overrun = 1'b1;
    @(negedge clk) clr_overrun = 1'b0;
    check("R5 cleared", overrun, 0);
  endtask

  task automatic t_glitch();
    @(negedge clk) rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (bit_clks() * 12) @(negedge clk);
    check("R6 glitch rejected", data_avail, 0);
    send(9'h0C3, 8, 0, 0, 1);
    check("R6 recovery", head_data, 9'h0C3);
    do_pop();
  endtask

  task automatic t_irq();
    irq_mode = 2'b00;
    irq_hi = 0;
    send(9'h001, 8, 0, 0, 1);
    send(9'h002, 8, 0, 0, 1);
    check("R7 pulse per char", irq_hi, 2);
    do_pop(); do_pop();
    irq_mode = 2'b10;
    @(negedge clk);
    check("R7 mode10 empty", irq, 0);
    send(9'h003, 8, 0, 0, 1);
    check("R7 mode10 data", irq, 1);
    do_pop();
    check("R7 mode10 drained", irq, 0);
    irq_mode = 2'b11;
    for (int i = 0; i < 3; i++) send(9'(i), 8, 0, 0, 1);
    check("R7 mode11 three", irq, 0);
    send(9'h004, 8, 0, 0, 1);
    check("R7 mode11 full", irq, 1);
    do_pop();
    check("R7 mode11 after pop", irq, 0);
    for (int i = 0; i < 3; i++) do_pop();
    irq_mode = 2'b00;
  endtask

  task automatic t_nine();
    nine_bit = 1'b1;
    send(9'h123, 9, 0, 0, 1);
    check("R8 nine data", head_data, 9'h123); do_pop();
    addr_detect = 1'b1;
    send(9'h045, 9, 0, 0, 1);
    check("R9 data word dropped", data_avail, 0);
    send(9'h1AA, 9, 0, 0, 1);
    check("R9 address kept", head_data, 9'h1AA); do_pop();
    addr_detect = 1'b0;
    send(9'h045, 9, 0, 0, 1);
    check("R9 filter off", head_data, 9'h045); do_pop();
    nine_bit = 1'b0;
  endtask

  task automatic t_baud();
    baud_div = 16'd3;
    repeat (100) @(negedge clk);
    send(9'h05A, 8, 0, 0, 1);
    check("R10 slow rate", head_data, 9'h05A);
    do_pop();
    baud_div = 16'd1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (40) @(negedge clk);
    t_reset();
    t_basic();
    t_order();
    t_parity();
    t_framing();
    t_overrun();
    t_glitch();
    t_irq();
    t_nine();
    t_baud();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule